// File: doc/BRIEF.md
# Gated Pulse Matched Filter Bank

This block is the acquisition front end of a digital impulse radio receiver. Each pulse repetition period, a bank of 1-bit ADCs delivers one sample vector. The block correlates that vector against a stored pulse template at every one-sample offset, with one matched filter per offset. It then reports which filter caught the strongest response and makes a hard bit decision from the sign of that response.

Every filter has its own enable input. A controller that has estimated where the channel energy lies can switch off filters that are not needed. A disabled filter stores a zero correlation and takes no part in the peak search. Setting all enables gives the full-parallel receiver. The bank evaluates all filters once per sample vector, not once per sample, and it accepts a new vector on every cycle.

Top module: `pmf_bank`

## Requirements
- R1: The sample vector is NUM_FILT+WIN_LEN bits wide. Filter k correlates sample bit k+j against template bit j for j = 0..WIN_LEN-1. A bit value of 1 counts as +1 and 0 counts as -1, so the correlation equals the number of agreements minus the number of disagreements. It lies in -WIN_LEN..+WIN_LEN and has the same parity as WIN_LEN.
- R2: A vector accepted at a rising edge with `sample_valid` high produces `result_valid` high for exactly one cycle, after the second rising edge that follows. Back-to-back vectors produce back-to-back results.
- R3: `peak_idx` is the enabled filter with the largest correlation magnitude. When magnitudes tie, the lowest index wins.
- R4: `peak_corr` is the signed correlation of the winning filter.
- R5: `peak_bit` is 1 when `peak_corr` is zero or positive and 0 when it is negative.
- R6: A disabled filter stores a correlation of zero. It never affects `peak_idx`, `peak_corr` or `peak_bit`, however strong its window is.
- R7: `filter_en` and `pulse_tmpl` are captured at the same edge as the samples. Changing them afterwards does not alter that vector's result.
- R8: When no filter is enabled, `no_peak` is 1 and `peak_idx`, `peak_corr` and `peak_bit` are all 0. Otherwise `no_peak` is 0.
- R9: After a synchronous reset, `result_valid`, `no_peak`, `peak_idx`, `peak_corr` and `peak_bit` are 0. Between results, the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new sample vector is present |
| samples | input | NUM_FILT+WIN_LEN | 1-bit samples of one repetition period, bit 0 earliest |
| filter_en | input | NUM_FILT | Per-filter enable, bit k enables filter k |
| pulse_tmpl | input | WIN_LEN | Pulse template, bit j matches window offset j |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| no_peak | output | 1 | No filter was enabled for this result |
| peak_idx | output | clog2(NUM_FILT) | Index of the winning filter |
| peak_corr | output | clog2(WIN_LEN)+2 | Signed correlation of the winning filter |
| peak_bit | output | 1 | Hard decision from the sign of peak_corr |

## Verification
The bench uses a 4-filter, 4-tap configuration and runs every 8-bit sample vector against every enable mask, for four templates. The templates are all-zero, all-one and two mixed patterns. The all-zero and all-one templates give equal-magnitude ties across offsets, which separates lowest-index tie breaking from other orderings. The mixed templates separate correct window alignment (sample k+j against template j) from reversed or shifted alignment. Sweeping the enable masks shows that disabled filters are excluded and that an empty mask raises the no-peak flag. Enables and template are scrambled just after capture to expose late sampling, outputs are rechecked one cycle later for hold, and a back-to-back burst confirms the two-edge latency holds when the pipeline is full.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    // Internal score width, wide enough for windows up to 16383 taps.
    localparam int SCORE_W = 16;

    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic [SCORE_W-1:0]        mag_t;

    // Outcome of the search over enabled filters.
    typedef struct packed {
        logic   found;
        mag_t   idx;
        score_t score;
    } peak_t;

    function automatic mag_t score_mag(score_t s);
        score_t neg;
        neg = -s;
        return s[SCORE_W-1] ? mag_t'(neg) : mag_t'(s);
    endfunction

endpackage

// File: rtl/pmf_filter.sv
module pmf_filter
    import pmf_pkg::*;
#(
    parameter int WIN_LEN = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               en,
    input  logic [WIN_LEN-1:0] win,
    input  logic [WIN_LEN-1:0] tmpl,
    output score_t             corr_q
);

    logic [WIN_LEN-1:0] miss;
    score_t             corr_d;

    // Agreements minus disagreements = WIN_LEN - 2 * disagreements.
    always_comb begin
        miss   = win ^ tmpl;
        corr_d = score_t'(WIN_LEN) - score_t'(2 * $countones(miss));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= '0;
        end else if (load) begin
            corr_q <= en ? corr_d : '0;
        end
    end

endmodule

// File: rtl/pmf_peak.sv
module pmf_peak
    import pmf_pkg::*;
#(
    parameter int NUM_FILT = 128
) (
    input  score_t [NUM_FILT-1:0] corr,
    input  logic   [NUM_FILT-1:0] en,
    output peak_t                 best
);

    mag_t best_mag;

    // Ascending scan with strict comparison keeps the lowest index on ties.
    always_comb begin
        best     = '0;
        best_mag = '0;
        for (int k = 0; k < NUM_FILT; k++) begin
            if (en[k] && (!best.found || (score_mag(corr[k]) > best_mag))) begin
                best.found = 1'b1;
                best.idx   = mag_t'(k);
                best.score = corr[k];
                best_mag   = score_mag(corr[k]);
            end
        end
    end

endmodule

// File: rtl/pmf_bank.sv
module pmf_bank
    import pmf_pkg::*;
#(
    parameter  int NUM_FILT = 128,
    parameter  int WIN_LEN  = 128,
    localparam int BUF_LEN  = NUM_FILT + WIN_LEN,
    localparam int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int CORR_W   = $clog2(WIN_LEN) + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_valid,
    input  logic [BUF_LEN-1:0]       samples,
    input  logic [NUM_FILT-1:0]      filter_en,
    input  logic [WIN_LEN-1:0]       pulse_tmpl,
    output logic                     result_valid,
    output logic                     no_peak,
    output logic [IDX_W-1:0]         peak_idx,
    output logic signed [CORR_W-1:0] peak_corr,
    output logic                     peak_bit
);

    score_t [NUM_FILT-1:0] corr_q;
    logic   [NUM_FILT-1:0] en_q;
    logic                  vld_q;
    peak_t                 best;

    // Stage 1: one filter per one-sample offset, all loaded together.
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        pmf_filter #(
            .WIN_LEN (WIN_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .load   (sample_valid),
            .en     (filter_en[g]),
            .win    (samples[g +: WIN_LEN]),
            .tmpl   (pulse_tmpl),
            .corr_q (corr_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= sample_valid;
            if (sample_valid) begin
                en_q <= filter_en;
            end
        end
    end

    // Stage 2: peak search over the enabled filters.
    pmf_peak #(
        .NUM_FILT (NUM_FILT)
    ) u_peak (
        .corr (corr_q),
        .en   (en_q),
        .best (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            no_peak      <= 1'b0;
            peak_idx     <= '0;
            peak_corr    <= '0;
            peak_bit     <= 1'b0;
        end else begin
            result_valid <= vld_q;
            if (vld_q) begin
                no_peak   <= !best.found;
                peak_idx  <= IDX_W'(best.idx);
                peak_corr <= CORR_W'(best.score);
                peak_bit  <= best.found && !best.score[SCORE_W-1];
            end
        end
    end

endmodule

// File: rtl/pmf_bank_chk.sv
module pmf_bank_chk
    import pmf_pkg::*;
#(
    parameter  int NUM_FILT = 128,
    parameter  int WIN_LEN  = 128,
    localparam int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int CORR_W   = $clog2(WIN_LEN) + 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sample_valid,
    input logic [NUM_FILT-1:0]      filter_en,
    input logic                     result_valid,
    input logic                     no_peak,
    input logic [IDX_W-1:0]         peak_idx,
    input logic signed [CORR_W-1:0] peak_corr,
    input logic                     peak_bit,
    input score_t [NUM_FILT-1:0]    corr_q,
    input logic [NUM_FILT-1:0]      en_q,
    input logic                     vld_q
);

    logic [NUM_FILT-1:0] stray;

    always_comb begin
        for (int k = 0; k < NUM_FILT; k++) begin
            stray[k] = (corr_q[k] != '0) && !en_q[k];
        end
    end

    AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ##2 result_valid); // R2

    AST_LATENCY_BACK: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(sample_valid, 2)); // R2

    AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (int'(peak_corr) <= WIN_LEN) && (int'(peak_corr) >= -WIN_LEN)
                         && (peak_corr[0] == WIN_LEN[0])); // R1

    AST_PEAK_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !no_peak) |-> ((($past(filter_en, 2) >> peak_idx) & NUM_FILT'(1)) != '0)); // R6

    AST_GATED_ZERO: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (stray == '0)); // R6

    AST_BIT_SIGN: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !no_peak) |-> (peak_bit == (peak_corr >= 0))); // R5

    AST_NO_PEAK: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (no_peak == ($past(filter_en, 2) == '0))); // R8

    AST_NO_PEAK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (result_valid && no_peak) |-> (peak_idx == '0) && (peak_corr == '0) && !peak_bit); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(peak_corr) && $stable(peak_idx) && $stable(no_peak)); // R9

endmodule

bind pmf_bank pmf_bank_chk #(
    .NUM_FILT (NUM_FILT),
    .WIN_LEN  (WIN_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .filter_en    (filter_en),
    .result_valid (result_valid),
    .no_peak      (no_peak),
    .peak_idx     (peak_idx),
    .peak_corr    (peak_corr),
    .peak_bit     (peak_bit),
    .corr_q       (corr_q),
    .en_q         (en_q),
    .vld_q        (vld_q)
);

// File: tb/pmf_bank_test.sv
module pmf_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NF  = 4;
    localparam int WL  = 4;
    localparam int BL  = NF + WL;
    localparam int IW  = 2;
    localparam int CW  = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_valid = 1'b0;
    logic [BL-1:0]        samples = '0;
    logic [NF-1:0]        filter_en = '0;
    logic [WL-1:0]        pulse_tmpl = '0;
    logic                 result_valid;
    logic                 no_peak;
    logic [IW-1:0]        peak_idx;
    logic signed [CW-1:0] peak_corr;
    logic                 peak_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmf_bank #(.NUM_FILT(NF), .WIN_LEN(WL)) uut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .samples      (samples),
        .filter_en    (filter_en),
        .pulse_tmpl   (pulse_tmpl),
        .result_valid (result_valid),
        .no_peak      (no_peak),
        .peak_idx     (peak_idx),
        .peak_corr    (peak_corr),
        .peak_bit     (peak_bit)
    );

    typedef struct {
        int found;
        int idx;
        int corr;
        int bitv;
    } exp_t;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t model(input logic [BL-1:0] s, input logic [WL-1:0] t,
                                   input logic [NF-1:0] en);
        exp_t e;
        int   bm;
        e  = '{0, 0, 0, 0};
        bm = -1;
        for (int f = 0; f < NF; f++) begin
            int acc = 0;
            for (int j = 0; j < WL; j++) acc += (s[f+j] == t[j]) ? 1 : -1;
            if (en[f]) begin
                int m = (acc < 0) ? -acc : acc;
                if (m > bm) begin
                    bm = m; e.found = 1; e.idx = f; e.corr = acc;
                end
            end
        end
        e.bitv = (e.found != 0 && e.corr >= 0) ? 1 : 0;
        return e;
    endfunction

    task automatic check_result(input exp_t e);
        chk(result_valid == 1'b1, "R2 result_valid", int'(result_valid), 1);
        chk(int'(no_peak) == (e.found ? 0 : 1), "R8 no_peak", int'(no_peak), e.found ? 0 : 1);
        chk(int'(peak_idx) == e.idx, "R3 peak_idx", int'(peak_idx), e.idx);
        chk(int'(peak_corr) == e.corr, "R4 R1 R6 peak_corr", int'(peak_corr), e.corr);
        chk(int'(peak_bit) == e.bitv, "R5 peak_bit", int'(peak_bit), e.bitv);
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic run_vec(input logic [BL-1:0] s, input logic [WL-1:0] t,
                           input logic [NF-1:0] en);
        exp_t e;
        e = model(s, t, en);
        samples = s; pulse_tmpl = t; filter_en = en; sample_valid = 1'b1;
        @(negedge clk);
        chk(result_valid == 1'b0, "R2 early", int'(result_valid), 0);
        // R7: late changes must not reach this vector's result
        sample_valid = 1'b0; filter_en = ~en; pulse_tmpl = ~t; samples = ~s;
        @(negedge clk);
        check_result(e);
        @(negedge clk);
        chk(result_valid == 1'b0, "R2 single strobe", int'(result_valid), 0);
        chk(int'(peak_corr) == e.corr && int'(peak_idx) == e.idx, "R9 hold",
            int'(peak_corr), e.corr);
    endtask

    initial begin
        logic [WL-1:0] tmpls [4];
        exp_t b0, b1, b2;
        tmpls[0] = 4'b0000; tmpls[1] = 4'b1011; tmpls[2] = 4'b0110; tmpls[3] = 4'b1111;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result_valid == 1'b0, "R9 reset valid", int'(result_valid), 0);
        chk(no_peak == 1'b0 && peak_bit == 1'b0, "R9 reset flags", int'(no_peak), 0);
        chk(peak_idx == '0 && peak_corr == '0, "R9 reset data", int'(peak_corr), 0);

        // R6 R8: ties broken by index shown via all-equal template
        for (int ti = 0; ti < 4; ti++) begin
            for (int m = 0; m < (1 << NF); m++) begin
                for (int s = 0; s < (1 << BL); s++) begin
                    run_vec(BL'(s), tmpls[ti], NF'(m));
                end
            end
        end

        // R2: back-to-back vectors
        b0 = model(8'b1011_0010, 4'b1011, 4'b1111);
        b1 = model(8'b0100_1101, 4'b1011, 4'b0110);
        b2 = model(8'b1111_0000, 4'b0110, 4'b0000);
        samples = 8'b1011_0010; pulse_tmpl = 4'b1011; filter_en = 4'b1111; sample_valid = 1'b1;
        @(negedge clk);
        samples = 8'b0100_1101; filter_en = 4'b0110;
        @(negedge clk);
        check_result(b0);
        samples = 8'b1111_0000; pulse_tmpl = 4'b0110; filter_en = 4'b0000;
        @(negedge clk);
        check_result(b1);
        sample_valid = 1'b0;
        @(negedge clk);
        check_result(b2);
        @(negedge clk);
        chk(result_valid == 1'b0, "R2 burst end", int'(result_valid), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule